// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bit-level half of a two-wire serial memory slave. A fast system clock oversamples the SCL and SDA pins. Each line passes through a two-flop synchronizer and then a three-sample majority filter. Start and stop conditions are decoded from the filtered levels. The block shifts in bytes, answers with acknowledge bits and shifts read data out. It drives SDA only as an open-drain pull-down enable.

The device-select byte carries a fixed type nibble of 1010, then three chip-enable bits compared against strap inputs, then a read/write flag. A separate memory sequencer sits behind the block and sees only byte-level events:
- start and stop pulses;
- each received byte, with its position since the last start;
- a request for the next byte to transmit;
- the master's acknowledge result after every transmitted byte.

While the sequencer asserts its busy input (an internal write cycle), the block ignores the bus entirely. A master can therefore poll for completion by sending device-select bytes until one is acknowledged.

The controller is one state machine with these states:
- IDLE: waits for a start.
- DEVSEL: shifts the select byte. At the 8th SCL rise it goes to ACK_DRIVE if the byte matches, or to IDLE if it does not.
- ACK_DRIVE: at the next SCL fall it pulls SDA low and goes to ACK_END.
- ACK_END: at the following SCL fall it releases SDA. It then goes to RD_DATA in read mode, or to WR_DATA in write mode.
- WR_DATA: shifts in a byte. At the 8th rise it goes to ACK_DRIVE.
- RD_DATA: shifts out a byte. At the 8th rise it goes to RD_RELEASE.
- RD_RELEASE: at the next fall it releases SDA and goes to RD_SAMPLE.
- RD_SAMPLE: at the 9th rise it samples the master's acknowledge. On an acknowledge it goes to RD_RELOAD; on a not-acknowledge it goes to IDLE.
- RD_RELOAD: at the next fall it loads the next byte and goes to RD_DATA.

Three transitions apply from any state:
- A start condition goes to DEVSEL.
- A stop condition goes to IDLE.
- Busy forces IDLE.

Top module: `tw_slave_frontend`

## Requirements
- R1: After reset, sda_oe is 0 and no event pulse (ev_start, ev_stop, rx_valid, rd_req, mst_ack_valid) is produced while the bus stays idle high.
- R2: A falling SDA while SCL is high gives one ev_start pulse. A rising SDA while SCL is high gives one ev_stop pulse. The two never occur in the same cycle.
- R3: The select byte is received MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal strap_ce[2:0]; bit 0 is 1 for read. On a match the block pulls SDA low (sda_oe=1) during the 9th clock. On a mismatch it never drives SDA and reports no byte until the next start.
- R4: In write mode each data byte is sampled on SCL rising edges, MSB first. It is reported with one rx_valid pulse carrying rx_data and rx_pos. rx_pos is 0 for the select byte, then counts up by one per byte and saturates. Every data byte is acknowledged, and sda_oe is 0 while rx_valid is high.
- R5: When a matched select byte has bit 0 = 1, rd_req pulses once and the byte on rd_data is then sent MSB first. sda_oe=1 sends a 0 bit. sda_oe changes only while SCL is low.
- R6: After each transmitted byte the master's 9th bit is sampled on the SCL rise and reported by mst_ack_valid, with mst_ack=1 when SDA was low. An acknowledge requests and sends the next byte. A not-acknowledge releases SDA for good until the next start.
- R7: While busy_in is 1, no start or stop is reported, sda_oe is 0 from the following cycle on, and no byte is acknowledged.
- R8: A start in the middle of a byte abandons it, clears sda_oe and restarts select-byte reception.
- R9: A one-sample pulse on SCL is filtered out and does not count as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock pin level |
| sda_in | input | 1 | Serial data pin level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_ce | input | 3 | Chip-enable strap value matched against select bits 3..1 |
| busy_in | input | 1 | Sequencer internal write in progress; bus ignored |
| rd_data | input | 8 | Next byte to transmit, valid from the cycle after rd_req |
| ev_start | output | 1 | Start condition pulse |
| ev_stop | output | 1 | Stop condition pulse |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte |
| rx_pos | output | POS_W | Byte position since last start (0 = select byte) |
| rd_req | output | 1 | Request for the next read byte |
| mst_ack_valid | output | 1 | Master acknowledge bit sampled |
| mst_ack | output | 1 | 1 when the master acknowledged the last byte |

## Verification
The hardest cases to reach are those where the pin timing works against the state machine. One is a start that arrives while a byte is half shifted. The other is a clock pulse so short that only the majority filter separates it from a real edge. The bench drives the pins from a cycle-counted open-drain master model with a wired-AND data line, so the slave's own pull-down appears on the line it samples. Directed sequences then cut a byte after four bits with a repeated start, and inject a single-cycle SCL pulse into every bit of a write. Read-out is checked against a byte stream that the bench itself advances on each rd_req. After a not-acknowledge, a further byte of clocks shows that the slave stays off the line.

// File: rtl/tw_front_pkg.sv
`timescale 1ns/1ps
package tw_front_pkg;

    localparam logic [3:0] TW_DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVSEL,
        S_ACK_DRIVE,
        S_ACK_END,
        S_WR_DATA,
        S_RD_DATA,
        S_RD_RELEASE,
        S_RD_SAMPLE,
        S_RD_RELOAD
    } tw_state_t;

endpackage

// File: rtl/tw_line_filter.sv
`timescale 1ns/1ps
module tw_line_filter #(
    parameter int SYNC_LEN = 2,
    parameter int WIN_LEN  = 3,
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int HALF = WIN_LEN / 2;

    logic [SYNC_LEN-1:0] sync_q;
    logic [WIN_LEN-1:0]  win_q;
    logic                lvl_q;
    logic                prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_LEN{IDLE_LVL}};
            win_q  <= {WIN_LEN{IDLE_LVL}};
            lvl_q  <= IDLE_LVL;
            prev_q <= IDLE_LVL;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], pin};
            win_q  <= {win_q[WIN_LEN-2:0], sync_q[SYNC_LEN-1]};
            lvl_q  <= ($countones(win_q) > HALF);
            prev_q <= lvl_q;
        end
    end

    assign lvl  = lvl_q;
    assign rise = lvl_q & ~prev_q;
    assign fall = ~lvl_q & prev_q;

endmodule

// File: rtl/tw_bit_engine.sv
`timescale 1ns/1ps
module tw_bit_engine
    import tw_front_pkg::*;
#(
    parameter int POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_hi,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_hi,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [2:0]       strap_ce,
    input  logic             busy_in,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic             ev_start,
    output logic             ev_stop,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [POS_W-1:0] rx_pos,
    output logic             rd_req,
    output logic             mst_ack_valid,
    output logic             mst_ack
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    tw_state_t        st_q, st_n;
    logic [6:0]       sh_q;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_q;
    logic [POS_W-1:0] pos_q;
    logic             rd_mode;

    logic       start_det, stop_det, last_bit, sel_hit;
    logic [7:0] full_byte;

    assign start_det = !busy_in && scl_hi && sda_fall;
    assign stop_det  = !busy_in && scl_hi && sda_rise;
    assign last_bit  = (bit_cnt == 3'd7);
    assign full_byte = {sh_q, sda_hi};
    assign sel_hit   = (full_byte[7:4] == TW_DEV_TYPE) && (full_byte[3:1] == strap_ce);

    // next-state logic
    always_comb begin
        st_n = st_q;
        if (busy_in)        st_n = S_IDLE;
        else if (start_det) st_n = S_DEVSEL;
        else if (stop_det)  st_n = S_IDLE;
        else begin
            unique case (st_q)
                S_IDLE:       ;
                S_DEVSEL:     if (scl_rise && last_bit) st_n = sel_hit ? S_ACK_DRIVE : S_IDLE;
                S_WR_DATA:    if (scl_rise && last_bit) st_n = S_ACK_DRIVE;
                S_ACK_DRIVE:  if (scl_fall) st_n = S_ACK_END;
                S_ACK_END:    if (scl_fall) st_n = rd_mode ? S_RD_DATA : S_WR_DATA;
                S_RD_DATA:    if (scl_rise && last_bit) st_n = S_RD_RELEASE;
                S_RD_RELEASE: if (scl_fall) st_n = S_RD_SAMPLE;
                S_RD_SAMPLE:  if (scl_rise) st_n = sda_hi ? S_IDLE : S_RD_RELOAD;
                S_RD_RELOAD:  if (scl_fall) st_n = S_RD_DATA;
                default:      st_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q          <= '0;
            bit_cnt       <= '0;
            tx_q          <= '0;
            pos_q         <= '0;
            rd_mode       <= 1'b0;
            sda_oe        <= 1'b0;
            ev_start      <= 1'b0;
            ev_stop       <= 1'b0;
            rx_valid      <= 1'b0;
            rx_data       <= '0;
            rx_pos        <= '0;
            rd_req        <= 1'b0;
            mst_ack_valid <= 1'b0;
            mst_ack       <= 1'b0;
        end else begin
            ev_start      <= 1'b0;
            ev_stop       <= 1'b0;
            rx_valid      <= 1'b0;
            rd_req        <= 1'b0;
            mst_ack_valid <= 1'b0;
            if (busy_in) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else if (start_det) begin
                ev_start <= 1'b1;
                sda_oe   <= 1'b0;
                bit_cnt  <= '0;
                pos_q    <= '0;
            end else if (stop_det) begin
                ev_stop <= 1'b1;
                sda_oe  <= 1'b0;
            end else begin
                case (st_q)
                    S_DEVSEL, S_WR_DATA: begin
                        if (scl_rise) begin
                            sh_q    <= full_byte[6:0];
                            bit_cnt <= bit_cnt + 3'd1;
                            if (last_bit && (st_q == S_WR_DATA || sel_hit)) begin
                                rx_valid <= 1'b1;
                                rx_data  <= full_byte;
                                rx_pos   <= pos_q;
                                if (pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
                                if (st_q == S_DEVSEL) begin
                                    rd_mode <= full_byte[0];
                                    rd_req  <= full_byte[0];
                                end
                            end
                        end
                    end
                    S_ACK_DRIVE: if (scl_fall) sda_oe <= 1'b1;
                    S_ACK_END: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                tx_q   <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    S_RD_DATA: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 3'd1;
                        if (scl_fall) sda_oe <= ~tx_q[3'd7 - bit_cnt];
                    end
                    S_RD_RELEASE: if (scl_fall) sda_oe <= 1'b0;
                    S_RD_SAMPLE: begin
                        if (scl_rise) begin
                            mst_ack_valid <= 1'b1;
                            mst_ack       <= ~sda_hi;
                            rd_req        <= ~sda_hi;
                        end
                    end
                    S_RD_RELOAD: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            tx_q    <= rd_data;
                            sda_oe  <= ~rd_data[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_start && ev_stop));

    // R4
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !sda_oe);

    // R5
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hi && $past(scl_hi) && !$past(busy_in) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_oe));

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_in |=> (!sda_oe && !ev_start && !ev_stop));

    // R8
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |-> !sda_oe);

endmodule

// File: rtl/tw_slave_frontend.sv
`timescale 1ns/1ps
module tw_slave_frontend #(
    parameter int SYNC_LEN = 2,
    parameter int WIN_LEN  = 3,
    parameter int POS_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic [2:0]       strap_ce,
    input  logic             busy_in,
    input  logic [7:0]       rd_data,
    output logic             ev_start,
    output logic             ev_stop,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [POS_W-1:0] rx_pos,
    output logic             rd_req,
    output logic             mst_ack_valid,
    output logic             mst_ack
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw, lvl, rise, fall;
    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        tw_line_filter #(
            .SYNC_LEN(SYNC_LEN),
            .WIN_LEN (WIN_LEN),
            .IDLE_LVL(1'b1)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (raw[g]),
            .lvl  (lvl[g]),
            .rise (rise[g]),
            .fall (fall[g])
        );
    end

    tw_bit_engine #(.POS_W(POS_W)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_hi       (lvl[0]),
        .scl_rise     (rise[0]),
        .scl_fall     (fall[0]),
        .sda_hi       (lvl[1]),
        .sda_rise     (rise[1]),
        .sda_fall     (fall[1]),
        .strap_ce     (strap_ce),
        .busy_in      (busy_in),
        .rd_data      (rd_data),
        .sda_oe       (sda_oe),
        .ev_start     (ev_start),
        .ev_stop      (ev_stop),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_pos       (rx_pos),
        .rd_req       (rd_req),
        .mst_ack_valid(mst_ack_valid),
        .mst_ack      (mst_ack)
    );

endmodule

// File: tb/tw_slave_frontend_test.sv
`timescale 1ns/1ps
module tw_slave_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 12;
    localparam logic [2:0] STRAP = 3'b101;
    // {expected ack, select byte, data byte}
    localparam logic [16:0] VEC [0:4] = '{17'h1AA5C, 17'h0A033, 17'h0BA11, 17'h1AA00, 17'h1AAFF};

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
    logic [7:0] rd_data = 8'h96;
    logic sda_oe, ev_start, ev_stop, rx_valid, rd_req, mst_ack_valid, mst_ack;
    logic [7:0] rx_data;
    logic [2:0] rx_pos;
    logic sda_line;
    assign sda_line = m_sda & ~sda_oe;

    int n_chk = 0, n_err = 0;
    int n_start = 0, n_stop = 0, n_rx = 0, n_rdreq = 0, n_mack = 0, n_oe = 0, n_bad_oe = 0;
    logic [7:0] last_rx = '0;
    logic [2:0] last_pos = '0;
    logic last_mack = 1'b0, oe_prev = 1'b0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_slave_frontend uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .strap_ce(STRAP), .busy_in(busy), .rd_data(rd_data), .ev_start(ev_start),
        .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_data(rx_data), .rx_pos(rx_pos),
        .rd_req(rd_req), .mst_ack_valid(mst_ack_valid), .mst_ack(mst_ack)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (ev_start) n_start <= n_start + 1;
            if (ev_stop)  n_stop  <= n_stop + 1;
            if (rx_valid) begin n_rx <= n_rx + 1; last_rx <= rx_data; last_pos <= rx_pos; end
            if (rd_req)   begin n_rdreq <= n_rdreq + 1; rd_data <= rd_data + 8'h3C; end
            if (mst_ack_valid) begin n_mack <= n_mack + 1; last_mack <= mst_ack; end
            if (sda_oe) n_oe <= n_oe + 1;
            if (sda_oe != oe_prev && m_scl) n_bad_oe <= n_bad_oe + 1;
            oe_prev <= sda_oe;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        wq(); m_sda = b;
        if (glitch) begin m_scl = 1'b1; @(negedge clk); m_scl = 1'b0; end
        wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_line; wq(); m_scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, input bit glitch, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        int s0, t0, r0, q0, o0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 events", n_start + n_stop + n_rx + n_rdreq + n_mack, 0);

        // vector table: select match / mismatch and write bytes
        for (int i = 0; i < 5; i++) begin
            s0 = n_start; t0 = n_stop; r0 = n_rx;
            bus_start();
            chk("R2 start", n_start, s0 + 1);
            put_byte(VEC[i][15:8], 1'b0, a);
            chk("R3 select ack", a, VEC[i][16]);
            put_byte(VEC[i][7:0], 1'b0, a);
            chk("R4 data ack", a, VEC[i][16]);
            if (VEC[i][16]) begin
                chk("R4 rx_data", last_rx, VEC[i][7:0]);
                chk("R4 rx_pos", last_pos, 1);
                chk("R4 rx count", n_rx, r0 + 2);
            end else begin
                chk("R3 mismatch silent", n_rx, r0);
            end
            bus_stop();
            chk("R2 stop", n_stop, t0 + 1);
        end

        // read with ack then nack
        q0 = n_rdreq;
        bus_start();
        put_byte(8'hAB, 1'b0, a);
        chk("R5 read select ack", a, 1);
        chk("R5 rd_req", n_rdreq, q0 + 1);
        get_byte(1'b1, d);
        chk("R5 first byte", d, 8'hD2);
        chk("R6 mst_ack", last_mack, 1);
        chk("R6 next rd_req", n_rdreq, q0 + 2);
        get_byte(1'b0, d);
        chk("R5 second byte", d, 8'h0E);
        chk("R6 nack seen", last_mack, 0);
        chk("R6 acks reported", n_mack, 2);
        o0 = n_oe;
        put_byte(8'h00, 1'b0, a);
        chk("R6 released after nack", n_oe, o0);
        bus_stop();
        chk("R6 no extra rd_req", n_rdreq, q0 + 2);

        // repeated start mid-byte
        r0 = n_rx;
        bus_start();
        for (int k = 0; k < 4; k++) put_bit(1'b1, 1'b0);
        bus_start();
        put_byte(8'hAA, 1'b0, a);
        chk("R8 restart select ack", a, 1);
        put_byte(8'h3A, 1'b0, a);
        chk("R8 data after restart", last_rx, 8'h3A);
        chk("R8 pos after restart", last_pos, 1);
        bus_stop();

        // busy: bus ignored, then poll succeeds
        busy = 1'b1;
        s0 = n_start; t0 = n_stop;
        bus_start();
        put_byte(8'hAA, 1'b0, a);
        chk("R7 no ack while busy", a, 0);
        bus_stop();
        chk("R7 no events while busy", (n_start - s0) + (n_stop - t0), 0);
        busy = 1'b0;
        bus_start();
        put_byte(8'hAA, 1'b0, a);
        chk("R7 poll ack after busy", a, 1);
        bus_stop();

        // SCL glitch rejection
        r0 = n_rx;
        bus_start();
        put_byte(8'hAA, 1'b1, a);
        chk("R9 select with glitches", a, 1);
        put_byte(8'hC6, 1'b1, a);
        chk("R9 data with glitches", last_rx, 8'hC6);
        chk("R9 byte count", n_rx, r0 + 2);
        bus_stop();

        chk("R5 oe changes only with scl low", n_bad_oe, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule